// File: doc/BRIEF.md
# Buck Phase PWM Gate Sequencer

This block is the digital heart of a single buck converter phase. It receives a phase clock and a set of one-bit comparator results: ramp above error level, ramp near floor, body brake, over-current, over-voltage, debug, synchronous-rectifier disable, negative current, and the sensed low-side-gate-low and switch-node-low flags. From these it produces a high-side gate enable, a low-side gate enable and a ramp-discharge strobe.

A reset-dominant PWM latch is set by each falling phase-clock edge and cleared when the ramp crosses the error level. The latch demand passes through a priority override stage and then an adaptive non-overlap sequencer. The sequencer moves between the two gates only through a state where both are off. Each turn-on waits for a two-flop synchronized sense flag, or for a timeout if the flag never arrives. The latch also handles 100% duty, and it skips one pulse after an over-current.

Top module: `buck_phase_seq`

## Requirements
- R1: A falling edge of phs_clk_i sets the PWM latch. The high-side enable then turns on and ramp_dis_o goes low.
- R2: The high-side enable rises only after the synchronized gl_low_i is seen high, and the low-side enable rises only after the synchronized sw_low_i is seen high. hs_en_o and ls_en_o are never high together, and every change from one gate to the other passes through at least one cycle with both low.
- R3: ramp_above_i high clears the latch. The high side turns off, ramp_dis_o stays high until the next set, and the low side turns on.
- R4: Clearing wins over setting. If ramp_above_i is high when a phase-clock fall arrives, the high side stays off and ramp_dis_o stays high.
- R5: If the latch is still set when the next phase-clock fall arrives, the high side is forced off and ramp_dis_o goes high. The high side is enabled again once ramp_floor_i goes high.
- R6: With brake_i high and ovp_i low, both gate enables go low one cycle later and stay low. The latch keeps running.
- R7: ocp_i high while the high side is demanded ends the pulse: the high side turns off and ramp_dis_o goes high. The next phase-clock fall is ignored, and the fall after it sets the latch again.
- R8: ovp_i high forces the high side off within one cycle and turns the low side on, for as long as ovp_i stays high.
- R9: With debug_i high and ovp_i low, both gate enables go low one cycle later. The latch and ramp_dis_o keep following the phase clock and the ramp.
- R10: With sync_dis_i and neg_cur_i both high (and ovp_i low), the low side is held off. Either flag alone has no effect.
- R11: The override order is over-voltage first, then debug, then body brake, then normal PWM.
- R12: If the awaited sense flag does not arrive, the gate turns on after TMO_CYC cycles in the both-off state.
- R13: During reset both gate enables are low and ramp_dis_o is high. After reset the low side comes on through its handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phs_clk_i | input | 1 | Phase clock; its falling edge starts a cycle |
| ramp_above_i | input | 1 | Ramp is above the error-amplifier level |
| ramp_floor_i | input | 1 | Ramp is within the floor window of the reference |
| brake_i | input | 1 | Error level is below the reference (body brake) |
| ocp_i | input | 1 | Cycle-by-cycle over-current trip |
| ovp_i | input | 1 | Over-voltage trip |
| debug_i | input | 1 | Isolate the phase: both gates off |
| sync_dis_i | input | 1 | Output is below 75% of the reference |
| neg_cur_i | input | 1 | Negative inductor current detected |
| gl_low_i | input | 1 | Sensed low-side gate is below threshold (asynchronous) |
| sw_low_i | input | 1 | Sensed switch node is low (asynchronous) |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| ramp_dis_o | output | 1 | Ramp discharge strobe |

## Verification
The properties assume that the fault and ramp flags are already synchronous to clk_i and stay stable across each clock edge. Only the phase clock and the two sense flags may arrive asynchronously, and those are synchronized inside the block. The stimulus changes every input between clock edges, and each flag level is held for many cycles. In its default mode the bench derives the sense flags from the block's own gate enables, which models a power stage that settles. For handshake and timeout cases it switches to manually driven sense levels.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [1:0] {
    GS_OFF = 2'd0,
    GS_HS  = 2'd1,
    GS_LS  = 2'd2
  } gate_st_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_req_t;
endpackage

// File: rtl/bps_sync.sv
module bps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[g] <= '0;
        else if (g == 0) stg_q[g] <= d_i;
        else             stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bps_pwm_latch.sv
module bps_pwm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phs_s_i,
  input  logic ramp_above_i,
  input  logic ramp_floor_i,
  input  logic ocp_i,
  output logic pwm_on_o,
  output logic ramp_dis_o
);
  logic phs_d_q, pwm_q, hold_q, skip_q;
  logic fall, ocp_hit;

  assign fall     = phs_d_q & ~phs_s_i;
  assign pwm_on_o = pwm_q & ~hold_q;
  assign ocp_hit  = ocp_i & pwm_on_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phs_d_q <= 1'b0;
      pwm_q   <= 1'b0;
      hold_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      phs_d_q <= phs_s_i;
      // reset dominant: ramp crossing or OC trip beats a set
      if (ramp_above_i || ocp_hit) begin
        pwm_q  <= 1'b0;
        hold_q <= 1'b0;
      end else if (fall && !skip_q) begin
        if (pwm_q) hold_q <= 1'b1;  // still high at new clock: 100% duty
        pwm_q <= 1'b1;
      end else if (hold_q && ramp_floor_i) begin
        hold_q <= 1'b0;
      end
      if (ocp_hit)   skip_q <= 1'b1;
      else if (fall) skip_q <= 1'b0;
    end
  end

  assign ramp_dis_o = ~pwm_q | hold_q;
endmodule

// File: rtl/bps_gate_seq.sv
module bps_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int TMO_CYC = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gate_req_t req_i,
  input  logic      gl_low_s_i,
  input  logic      sw_low_s_i,
  output logic      hs_en_o,
  output logic      ls_en_o
);
  localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

  gate_st_e       st_q, st_d;
  logic [CW-1:0]  cnt_q;
  logic           tmo;

  assign tmo = (cnt_q == CW'(TMO_CYC - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_OFF: begin
        if (req_i.hs && (gl_low_s_i || tmo))      st_d = GS_HS;
        else if (req_i.ls && (sw_low_s_i || tmo)) st_d = GS_LS;
      end
      GS_HS:   if (!req_i.hs) st_d = GS_OFF;
      GS_LS:   if (!req_i.ls) st_d = GS_OFF;
      default: st_d = GS_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= GS_OFF;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == GS_OFF && st_d == GS_OFF && (req_i.hs || req_i.ls))
        cnt_q <= cnt_q + 1'b1;
      else
        cnt_q <= '0;
    end
  end

  assign hs_en_o = (st_q == GS_HS);
  assign ls_en_o = (st_q == GS_LS);
endmodule

// File: rtl/buck_phase_seq.sv
module buck_phase_seq
  import buck_seq_pkg::*;
#(
  parameter int TMO_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phs_clk_i,
  input  logic ramp_above_i,
  input  logic ramp_floor_i,
  input  logic brake_i,
  input  logic ocp_i,
  input  logic ovp_i,
  input  logic debug_i,
  input  logic sync_dis_i,
  input  logic neg_cur_i,
  input  logic gl_low_i,
  input  logic sw_low_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic ramp_dis_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] async_raw, async_s;
  logic             pwm_on;
  gate_req_t        req;

  assign async_raw = {phs_clk_i, gl_low_i, sw_low_i};

  bps_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_raw),
    .q_o    (async_s)
  );

  bps_pwm_latch u_pwm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phs_s_i      (async_s[2]),
    .ramp_above_i (ramp_above_i),
    .ramp_floor_i (ramp_floor_i),
    .ocp_i        (ocp_i),
    .pwm_on_o     (pwm_on),
    .ramp_dis_o   (ramp_dis_o)
  );

  // override priority: ovp > debug > brake > pwm
  always_comb begin
    if (ovp_i) begin
      req.hs = 1'b0;
      req.ls = 1'b1;
    end else if (debug_i || brake_i) begin
      req.hs = 1'b0;
      req.ls = 1'b0;
    end else begin
      req.hs = pwm_on;
      req.ls = ~pwm_on & ~(sync_dis_i & neg_cur_i);
    end
  end

  bps_gate_seq #(.TMO_CYC(TMO_CYC)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .gl_low_s_i (async_s[1]),
    .sw_low_s_i (async_s[0]),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o)
  );
endmodule

// File: rtl/bps_checker.sv
module bps_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ramp_above_i,
  input logic brake_i,
  input logic ovp_i,
  input logic debug_i,
  input logic sync_dis_i,
  input logic neg_cur_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic ramp_dis_o
);
  AST_HS_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> !$past(ls_en_o)); // R2
  AST_LS_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o)); // R2
  AST_RAMP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_above_i |=> ramp_dis_o); // R4
  AST_BRAKE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brake_i && !ovp_i) |=> (!hs_en_o && !ls_en_o)); // R6
  AST_OVP_HS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |=> !hs_en_o); // R8
  AST_DEBUG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_i && !ovp_i) |=> (!hs_en_o && !ls_en_o)); // R9
  AST_SYNC_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_dis_i && neg_cur_i && !ovp_i) |=> !ls_en_o); // R10
endmodule

bind buck_phase_seq bps_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ramp_above_i (ramp_above_i),
  .brake_i      (brake_i),
  .ovp_i        (ovp_i),
  .debug_i      (debug_i),
  .sync_dis_i   (sync_dis_i),
  .neg_cur_i    (neg_cur_i),
  .hs_en_o      (hs_en_o),
  .ls_en_o      (ls_en_o),
  .ramp_dis_o   (ramp_dis_o)
);

// File: tb/buck_phase_seq_test.sv
module buck_phase_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phs = 1'b0, ra = 1'b0, floor_f = 1'b0, brk = 1'b0, ocp = 1'b0;
  logic ovp = 1'b0, dbg = 1'b0, sd = 1'b0, nc = 1'b0;
  logic model_on = 1'b1, gl_man = 1'b0, sw_man = 1'b0;
  logic gl_low, sw_low;
  logic hs, ls, dis;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  // power-stage model: sense flags follow the opposite gate
  always_comb begin
    gl_low = model_on ? !ls : gl_man;
    sw_low = model_on ? !hs : sw_man;
  end

  buck_phase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .phs_clk_i(phs), .ramp_above_i(ra),
    .ramp_floor_i(floor_f), .brake_i(brk), .ocp_i(ocp), .ovp_i(ovp),
    .debug_i(dbg), .sync_dis_i(sd), .neg_cur_i(nc), .gl_low_i(gl_low),
    .sw_low_i(sw_low), .hs_en_o(hs), .ls_en_o(ls), .ramp_dis_o(dis)
  );

  // {ovp,dbg,brk,sd,nc, pulse,ra, hs,ls,dis}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    10'b00000_10_100, 10'b00000_01_011, 10'b00000_11_011, 10'b00100_10_000,
    10'b01000_01_001, 10'b11000_01_011, 10'b10000_10_010, 10'b00011_01_001,
    10'b00010_01_011, 10'b00000_10_100
  };

  function automatic string vreq(int i);
    case (i)
      0, 9:    return "R1";
      1, 2:    return "R3";
      3:       return "R6";
      4:       return "R9";
      5:       return "R11";
      6:       return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse();
    phs = 1'b1; cyc(4);
    phs = 1'b0; cyc(1);
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hs,ls,dis} actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    cyc(3);
    chk("R13 reset", {hs, ls, dis}, 3'b001);
    rst_n = 1'b1;
    cyc(20);
    chk("R13 post-reset", {hs, ls, dis}, 3'b011);

    for (int i = 0; i < NV; i++) begin
      {ovp, dbg, brk, sd, nc} = VEC[i][9:5];
      ra = 1'b0;
      cyc(5);
      if (VEC[i][4]) pulse();
      cyc(25);
      ra = VEC[i][3];
      cyc(25);
      chk(vreq(i), {hs, ls, dis}, VEC[i][2:0]);
    end
    {ovp, dbg, brk, sd, nc} = '0;

    // R4: clear held during a fall
    ra = 1'b1; cyc(10);
    bad = 0;
    phs = 1'b1;
    for (int k = 0; k < 24; k++) begin
      if (k == 4) phs = 1'b0;
      cyc(1);
      if (hs) bad++;
    end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R4: hs-high cycles actual=%0d expected=0", bad);
    end
    chk("R4 dis", {hs, ls, dis}, 3'b011);
    ra = 1'b0; cyc(5);

    // R5: 100% duty
    pulse(); cyc(20);
    chk("R1 set", {hs, ls, dis}, 3'b100);
    pulse(); cyc(15);
    chk("R5 forced off", {hs, dis}, {1'b0, 1'b0, 1'b1});
    floor_f = 1'b1; cyc(20);
    chk("R5 re-enable", {hs, ls, dis}, 3'b100);
    floor_f = 1'b0; cyc(2);

    // R7: over-current skip
    ocp = 1'b1; cyc(3); ocp = 1'b0; cyc(15);
    chk("R7 terminate", {hs, ls, dis}, 3'b011);
    pulse(); cyc(20);
    chk("R7 skipped", {hs, ls, dis}, 3'b011);
    pulse(); cyc(20);
    chk("R7 resume", {hs, ls, dis}, 3'b100);

    // R2: high side waits for gate-low sense
    ra = 1'b1; cyc(20); ra = 1'b0; cyc(5);
    gl_man = 1'b0; sw_man = 1'b0; model_on = 1'b0;
    pulse(); cyc(8);
    chk("R2 wait gl", {hs, ls, dis}, 3'b000);
    gl_man = 1'b1; cyc(5);
    chk("R2 gl seen", {hs, ls, dis}, 3'b100);

    // R12: low side released by timeout with switch-node sense stuck low
    ra = 1'b1; cyc(8);
    chk("R12 waiting", {hs, ls, dis}, 3'b001);
    cyc(30);
    chk("R12 timeout", {hs, ls, dis}, 3'b011);
    ra = 1'b0; model_on = 1'b1; cyc(5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule